// File: doc/BRIEF.md
# External Memory Access Stretch Sequencer

This block times one external data access at a time, such as a load from or a store to slow off-chip memory. Each access is counted in machine cycles, which a shared timing generator marks with a one-clock `mc_tick`. A stored 3-bit stretch setting makes an off-chip access longer, so a slow device sees a wide read or write strobe and needs no wait-state logic of its own. An access that hits on-chip SRAM always takes the shortest length and ignores the setting.

A start request in idle captures the direction, the on-chip hit flag and the length for that access. The first machine cycle runs with both strobes high. From the second machine cycle to the end of the last one, only the strobe for the chosen direction is driven low. One clock after the final tick, a single-clock done pulse is raised. From that clock on the sequencer is idle again, so a new start can be accepted in the same clock as the done pulse.

Top module: `xmem_stretch_seq`

## Requirements
- R1: While reset is held, and just after it, `rd_n` and `wr_n` are high and `acc_done` is low. The stretch setting resets to 1, so an off-chip access made before any load lasts 3 ticks.
- R2: An off-chip access (`acc_onchip`=0) lasts 2 + S machine cycles, where S is the stored stretch value (0..7). It ends on the tick numbered 2+S, counted from the first tick after the start clock.
- R3: An access with `acc_onchip`=1 lasts exactly 2 machine cycles, whatever the stretch value.
- R4: `acc_write`=0 selects a read, which drives only `rd_n`. `acc_write`=1 selects a write, which drives only `wr_n`. The strobe that is not selected stays high for the whole access, and the two are never low together.
- R5: The selected strobe goes low at the first tick and returns high at the final tick, so it is low for (length − 1) machine cycles. It changes only at a clock where `mc_tick` is high.
- R6: `acc_done` is high for exactly one clock. That clock follows the clock edge at which the final tick is taken.
- R7: `acc_start` raised while an access is in progress has no effect. The current access keeps its length and strobe, and no further access follows it.
- R8: `cfg_load`=1 stores `cfg_stretch` as the new stretch value. The length of an access is fixed at its start, so a load during an access affects only later accesses.
- R9: A start raised in the same clock as `acc_done` is accepted and begins a new access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Store `cfg_stretch` into the stretch setting |
| cfg_stretch | input | 3 | New stretch value |
| acc_start | input | 1 | Request to begin an access (taken only when idle) |
| acc_write | input | 1 | 1 = write, 0 = read; captured at start |
| acc_onchip | input | 1 | Access hits on-chip SRAM; captured at start |
| mc_tick | input | 1 | One-clock marker at the end of each machine cycle |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| acc_done | output | 1 | One-clock pulse after an access finishes |

## Verification
Two pairs of events can fall in the same clock. The first is a new start and the done pulse of the previous access. The second is a stretch load and a running access whose length is already fixed. The bench raises a start in the very clock where it sees `acc_done`. It then measures the second access in ticks and strobe-low clocks, and expects the full programmed length. It also loads a new stretch value in the middle of an access. It expects the old length for that access and the new length for the next one. A start placed inside a running access is judged by the unchanged tick count, and by idle strobes and no done pulse afterwards.

// File: rtl/xs_pkg.sv
package xs_pkg;

   typedef enum logic {
      XS_DIR_READ  = 1'b0,
      XS_DIR_WRITE = 1'b1
   } xs_dir_e;

   // Longest access in machine cycles for a given base and stretch width
   function automatic int xs_max_len(input int base, input int sw);
      return base + (1 << sw) - 1;
   endfunction

endpackage

// File: rtl/xs_cfg_reg.sv
module xs_cfg_reg #(
   parameter int STRETCH_W   = 3,
   parameter int STRETCH_RST = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [STRETCH_W-1:0] value,
   output logic [STRETCH_W-1:0] stretch_q
);

   localparam logic [STRETCH_W-1:0] RST_VAL = STRETCH_W'(STRETCH_RST);

   always_ff @(posedge clk) begin
      if (!rst_n)
         stretch_q <= RST_VAL;
      else if (load)
         stretch_q <= value;
   end

   // Setting changes only through a load
   p_hold_setting_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(stretch_q));

endmodule

// File: rtl/xs_len_calc.sv
module xs_len_calc #(
   parameter int STRETCH_W     = 3,
   parameter int BASE_CYCLES   = 2,
   parameter int CNT_W         = 4,
   parameter bit ONCHIP_BYPASS = 1'b1
) (
   input  logic [STRETCH_W-1:0] stretch,
   input  logic                 onchip,
   output logic [CNT_W-1:0]     len
);

   localparam logic [CNT_W-1:0] BASE_LEN = CNT_W'(BASE_CYCLES);

   logic [CNT_W-1:0] stretched;
   assign stretched = BASE_LEN + CNT_W'(stretch);

   generate
      if (ONCHIP_BYPASS) begin : g_bypass
         assign len = onchip ? BASE_LEN : stretched;
      end else begin : g_always_stretch
         logic unused_onchip;
         assign unused_onchip = onchip;
         assign len = stretched;
      end
   endgenerate

endmodule

// File: rtl/xs_seq.sv
module xs_seq
   import xs_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  xs_dir_e          dir_in,
   input  logic [CNT_W-1:0] len_in,
   input  logic             tick,
   output logic             busy,
   output logic             strobe_on,
   output xs_dir_e          dir_q,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] len_q;
   logic             last_mc;

   assign last_mc = (cnt_q == len_q - CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         strobe_on <= 1'b0;
         dir_q     <= XS_DIR_READ;
         cnt_q     <= '0;
         len_q     <= '0;
         done      <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy      <= 1'b1;
               strobe_on <= 1'b0;
               dir_q     <= dir_in;
               cnt_q     <= '0;
               len_q     <= len_in;
            end
         end else if (tick) begin
            if (last_mc) begin
               busy      <= 1'b0;
               strobe_on <= 1'b0;
               done      <= 1'b1;
            end else begin
               cnt_q     <= cnt_q + CNT_W'(1);
               strobe_on <= 1'b1;
            end
         end
      end
   end

   p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt_q < len_q));

   p_done_one_clock_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !strobe_on));

   p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick) |=> ($stable(cnt_q) && $stable(len_q) && $stable(dir_q) && busy));

   p_dir_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !$past(!busy)) |-> $stable(dir_q));

endmodule

// File: rtl/xmem_stretch_seq.sv
module xmem_stretch_seq
   import xs_pkg::*;
#(
   parameter int STRETCH_W     = 3,
   parameter int BASE_CYCLES   = 2,
   parameter int STRETCH_RST   = 1,
   parameter bit ONCHIP_BYPASS = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_load,
   input  logic [STRETCH_W-1:0] cfg_stretch,
   input  logic                 acc_start,
   input  logic                 acc_write,
   input  logic                 acc_onchip,
   input  logic                 mc_tick,
   output logic                 rd_n,
   output logic                 wr_n,
   output logic                 acc_done
);

   localparam int MAX_LEN = xs_max_len(BASE_CYCLES, STRETCH_W);
   localparam int CNT_W   = $clog2(MAX_LEN + 1);

   generate
      if (STRETCH_W < 1 || STRETCH_W > 8) begin : g_bad_width
         $error("stretch width out of range");
      end
      if (BASE_CYCLES < 2) begin : g_bad_base
         $error("base length must be at least two machine cycles");
      end
      if (STRETCH_RST < 0 || STRETCH_RST >= (1 << STRETCH_W)) begin : g_bad_rst
         $error("stretch reset value does not fit the field");
      end
   endgenerate

   logic [STRETCH_W-1:0] stretch_q;
   logic [CNT_W-1:0]     len_new;
   logic                 busy;
   logic                 strobe_on;
   xs_dir_e              dir_q;
   xs_dir_e              dir_in;

   assign dir_in = acc_write ? XS_DIR_WRITE : XS_DIR_READ;

   xs_cfg_reg #(
      .STRETCH_W  (STRETCH_W),
      .STRETCH_RST(STRETCH_RST)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cfg_load),
      .value    (cfg_stretch),
      .stretch_q(stretch_q)
   );

   xs_len_calc #(
      .STRETCH_W    (STRETCH_W),
      .BASE_CYCLES  (BASE_CYCLES),
      .CNT_W        (CNT_W),
      .ONCHIP_BYPASS(ONCHIP_BYPASS)
   ) u_len (
      .stretch(stretch_q),
      .onchip (acc_onchip),
      .len    (len_new)
   );

   xs_seq #(
      .CNT_W(CNT_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (acc_start),
      .dir_in   (dir_in),
      .len_in   (len_new),
      .tick     (mc_tick),
      .busy     (busy),
      .strobe_on(strobe_on),
      .dir_q    (dir_q),
      .done     (acc_done)
   );

   assign rd_n = ~(strobe_on && (dir_q == XS_DIR_READ));
   assign wr_n = ~(strobe_on && (dir_q == XS_DIR_WRITE));

   p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n));

   p_strobe_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !mc_tick |=> ($stable(rd_n) && $stable(wr_n)));

   p_strobe_needs_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n || !wr_n) |-> busy);

endmodule

// File: tb/tb_xmem_stretch_seq.sv
module tb_xmem_stretch_seq;

   localparam int CLK_P  = 10;
   localparam int TICK_P = 3;
   localparam int NVEC   = 8;

   // {write, onchip, stretch[2:0], expected length[3:0]}
   localparam logic [8:0] VEC [NVEC] = '{
      {1'b0, 1'b0, 3'd0, 4'd2},
      {1'b1, 1'b0, 3'd7, 4'd9},
      {1'b0, 1'b0, 3'd3, 4'd5},
      {1'b1, 1'b1, 3'd7, 4'd2},
      {1'b0, 1'b1, 3'd0, 4'd2},
      {1'b1, 1'b0, 3'd5, 4'd7},
      {1'b0, 1'b0, 3'd7, 4'd9},
      {1'b1, 1'b0, 3'd2, 4'd4}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_load = 1'b0;
   logic [2:0] cfg_stretch = 3'd0;
   logic       acc_start = 1'b0;
   logic       acc_write = 1'b0;
   logic       acc_onchip = 1'b0;
   logic       mc_tick = 1'b0;
   logic       rd_n, wr_n, acc_done;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   xmem_stretch_seq dut (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_stretch(cfg_stretch),
      .acc_start(acc_start), .acc_write(acc_write), .acc_onchip(acc_onchip),
      .mc_tick(mc_tick), .rd_n(rd_n), .wr_n(wr_n), .acc_done(acc_done)
   );

   task automatic chk(input int act, input int exp, input string req, input string what);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic load_cfg(input logic [2:0] s);
      @(negedge clk);
      cfg_load = 1'b1;
      cfg_stretch = s;
      @(negedge clk);
      cfg_load = 1'b0;
   endtask

   // Raise start at the current negedge; the caller is at a negedge.
   task automatic raise_start(input logic w, input logic h);
      acc_start = 1'b1;
      acc_write = w;
      acc_onchip = h;
   endtask

   // Follows one access that started at the previous posedge.
   // Returns at the negedge where acc_done is seen high.
   task automatic measure(input int exp_len, input logic w, input string req,
                          input bit poke_start, input bit poke_cfg);
      int ticks = 0;
      int low_sel = 0;
      int low_oth = 0;
      bit seen = 1'b0;
      for (int step = 0; step < 200; step++) begin
         @(negedge clk);
         acc_start = 1'b0;
         mc_tick = 1'b0;
         cfg_load = 1'b0;
         if (acc_done) begin
            seen = 1'b1;
            break;
         end
         if ((w ? wr_n : rd_n) == 1'b0) low_sel++;
         if ((w ? rd_n : wr_n) == 1'b0) low_oth++;
         if (poke_start && (step == 4 || step == 5)) begin
            acc_start = 1'b1;
            acc_write = ~w;
            acc_onchip = 1'b0;
         end
         if (poke_cfg && step == 1) begin
            cfg_load = 1'b1;
            cfg_stretch = 3'd6;
         end
         if (step % TICK_P == TICK_P - 1) begin
            mc_tick = 1'b1;
            ticks++;
         end
      end
      chk(int'(seen), 1, req, "done seen");
      chk(ticks, exp_len, req, "machine cycles");
      chk(low_sel, (exp_len - 1) * TICK_P, "R5", "selected strobe low clocks");
      chk(low_oth, 0, "R4", "other strobe low clocks");
   endtask

   task automatic check_done_width();
      @(negedge clk);
      chk(int'(acc_done), 0, "R6", "done width one clock");
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=expired expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(int'(rd_n), 1, "R1", "rd_n in reset");
      chk(int'(wr_n), 1, "R1", "wr_n in reset");
      chk(int'(acc_done), 0, "R1", "done in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk(int'(rd_n & wr_n), 1, "R1", "strobes idle after reset");

      // R1: default stretch gives a 3-cycle off-chip access
      raise_start(1'b0, 1'b0);
      measure(3, 1'b0, "R1", 1'b0, 1'b0);
      check_done_width();

      // R2 R3 R4 R5 R6: table walk
      for (int i = 0; i < NVEC; i++) begin
         load_cfg(VEC[i][6:4]);
         raise_start(VEC[i][8], VEC[i][7]);
         measure(int'(VEC[i][3:0]), VEC[i][8], VEC[i][7] ? "R3" : "R2", 1'b0, 1'b0);
         check_done_width();
      end

      // R7: start during an access is ignored
      load_cfg(3'd3);
      @(negedge clk);
      raise_start(1'b0, 1'b0);
      measure(5, 1'b0, "R7", 1'b1, 1'b0);
      begin
         int extra_done = 0;
         int extra_low = 0;
         for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            mc_tick = (k % TICK_P == TICK_P - 1);
            if (acc_done) extra_done++;
            if (!rd_n || !wr_n) extra_low++;
         end
         mc_tick = 1'b0;
         chk(extra_done, 0, "R7", "no follow-on done");
         chk(extra_low, 0, "R7", "no follow-on strobe");
      end

      // R8: load during an access keeps the latched length
      load_cfg(3'd1);
      @(negedge clk);
      raise_start(1'b1, 1'b0);
      measure(3, 1'b1, "R8", 1'b0, 1'b1);
      // R9: start in the done clock, uses the new setting (6 -> 8 cycles)
      raise_start(1'b0, 1'b0);
      measure(8, 1'b0, "R9", 1'b0, 1'b0);
      raise_start(1'b1, 1'b1);
      measure(2, 1'b1, "R9", 1'b0, 1'b0);
      check_done_width();

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule